// File: doc/BRIEF.md
# Flash Operation Status Bit Generator

This block belongs to a behavioural controller for a parallel NOR flash. While a program or erase operation runs inside the device, a read does not return array contents. It returns status encoded in two bits of the read data. This block builds that read data. Bit 7 is the polling bit: it reflects the programmed datum or the erase state. Bit 6 is the toggle bit: it flips on every read cycle while work is in progress. All other bits pass the array data through unchanged.

The command decoder drives three things. It issues a one-cycle `op_start` pulse at the rising edge of the final write-enable pulse of a command sequence. It reports the current operation kind, and it raises `busy` while the internal engine works. When the target of a program is protected, or when every sector picked for an erase is protected, no engine work happens. In that case this block runs its own timed false-busy window and then lets array reads through again. Window lengths are given in nanoseconds and converted to clock cycles through `CLK_PERIOD_NS`.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, `rd_data` equals `array_data` and no status window is open.
- R2: With `op_kind`=0 (program) and `busy` high, `rd_data[7]` is the inverse of bit 7 of the datum latched at `op_start`. Once `busy` drops, bit 7 is the array bit. Bits 5..0 always pass `array_data` through.
- R3: With `op_kind`=1 (erase) and `busy` high, `rd_data[7]` is 0. Once `busy` drops, bit 7 is the array bit.
- R4: A start of kind 0, 1 or 3 clears the toggle bit to 0. While toggling is enabled, each read cycle inverts it, so the first read after a start shows 1 on `rd_data[6]`, the second shows 0, and so on.
- R5: With `op_kind`=3 (program while erase is suspended) and `busy` high, bit 7 is the inverted datum bit and bit 6 toggles per read.
- R6: With `op_kind`=2 (erase suspended), `rd_data[7]` is 1 and `rd_data[6]` holds its last value; reads do not change it. Returning to kind 1 without a start resumes toggling from that value.
- R7: A read cycle is counted once, on the cycle where `oe_n` and `ce_n` are first both low. A strobe held low counts as one read. Either strobe can open or close the read. Only one strobe low counts as no read.
- R8: A start of kind 0 or 3 with `prog_prot` high opens a polling window of `PROG_DQ7_NS` and a toggle window of `PROG_DQ6_NS`, both measured from the start. Bit 7 shows the inverted datum and bit 6 toggles only inside its own window. Reads after both windows return array data.
- R9: A start of kind 1 with `erase_prot` high opens both windows for `ERASE_PROT_NS`. During that time bit 7 is 0 and bit 6 toggles. After it, reads return array data.
- R10: With `busy` low, kind other than 2, and no window open, `rd_data` equals `array_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | One-cycle pulse when a program/erase command completes |
| op_kind | input | 2 | 0 program, 1 erase, 2 erase suspended, 3 program in suspend |
| busy | input | 1 | Internal program/erase engine running |
| prog_data | input | 8 | Datum being programmed, latched at start |
| prog_prot | input | 1 | Program target sector is protected (sampled at start) |
| erase_prot | input | 1 | All sectors picked for erase are protected (sampled at start) |
| oe_n | input | 1 | Output enable, active low |
| ce_n | input | 1 | Chip enable, active low |
| array_data | input | 8 | Data read from the array at the current address |
| rd_data | output | 8 | Read data with status bits substituted |

## Verification
The assertions assume the lengths satisfy `PROG_DQ6_NS` ≥ `PROG_DQ7_NS`. They also assume `op_start` is a single-cycle pulse, and that `busy` is never high while a protected window runs. The stimulus keeps `busy` low for protected starts. It pulses `op_start` for exactly one cycle and changes `op_kind` only between reads. Each read holds the strobes low for several cycles, so one read cycle is exactly one leading edge.

// File: rtl/flash_status_pkg.sv
// Package: shared operation-kind codes and the ns-to-cycle conversion
// used by the status bit generator.
package flash_status_pkg;

    typedef enum logic [1:0] {
        OPK_PROG  = 2'd0,
        OPK_ERASE = 2'd1,
        OPK_SUSP  = 2'd2,
        OPK_SPROG = 2'd3
    } op_kind_e;

    // Round a duration in ns up to whole clock cycles (at least 1).
    function automatic int ns_to_cycles(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/fsg_read_edge.sv
// Read-cycle detector. A read is open while both active-low strobes are
// low; one pulse is produced on the first clock of each open read.
// Assumes the strobes are already in the clk domain.
module fsg_read_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n,
    input  logic ce_n,
    output logic rd_edge
);
    logic rd_open;
    logic rd_open_q;

    assign rd_open = !oe_n && !ce_n;

    // Remember last cycle's read state for leading-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_open_q <= 1'b0;
        else        rd_open_q <= rd_open;
    end

    assign rd_edge = rd_open && !rd_open_q;
endmodule

// File: rtl/fsg_toggle_bit.sv
// Toggle bit register. It clears on a new operation, and it inverts on each
// read edge while enabled. The clear wins over a same-cycle read.
module fsg_toggle_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic enable,
    input  logic rd_edge,
    output logic tog_q
);
    // Hold, clear or invert the toggle state.
    always_ff @(posedge clk) begin
        if (!rst_n)                  tog_q <= 1'b0;
        else if (clear)              tog_q <= 1'b0;
        else if (enable && rd_edge)  tog_q <= !tog_q;
    end
endmodule

// File: rtl/fsg_phantom_timer.sv
// False-busy window timer for protected targets. A protected start loads
// two limits (program or erase set) and counts cycles from the start.
// win7 is open for lim7 cycles and win6 for lim6 cycles.
// Assumes P6_CYC >= P7_CYC. Any start without protection cancels a window.
module fsg_phantom_timer #(
    parameter int P7_CYC = 250,
    parameter int P6_CYC = 500,
    parameter int E_CYC  = 25000,
    localparam int MAXC  = (E_CYC > P6_CYC) ? E_CYC : P6_CYC,
    localparam int CW    = $clog2(MAXC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_prot,
    input  logic cancel,
    input  logic sel_erase,
    output logic win7,
    output logic win6,
    output logic is_erase
);
    logic          run;
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim7;
    logic [CW-1:0] lim6;

    // Load limits on a protected start, count while running, stop at lim6.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= 1'b0;
            cnt      <= '0;
            lim7     <= '0;
            lim6     <= '0;
            is_erase <= 1'b0;
        end else if (start_prot) begin
            run      <= 1'b1;
            cnt      <= '0;
            lim7     <= sel_erase ? CW'(E_CYC) : CW'(P7_CYC);
            lim6     <= sel_erase ? CW'(E_CYC) : CW'(P6_CYC);
            is_erase <= sel_erase;
        end else if (cancel) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (run) begin
            if (cnt == lim6 - CW'(1)) run <= 1'b0;
            cnt <= cnt + CW'(1);
        end
    end

    assign win7 = run && (cnt < lim7);
    assign win6 = run;
endmodule

// File: rtl/flash_status_gen.sv
// Status bit generator for a NOR-flash behavioural controller.
// It substitutes bit 7 (polling) and bit 6 (toggle) of read data while a
// program/erase runs, while erase is suspended, or during a protected
// false-busy window. Assumes op_start is a one-cycle pulse and that busy
// stays low for protected starts.
module flash_status_gen #(
    parameter int CLK_PERIOD_NS = 4,
    parameter int PROG_DQ7_NS   = 1000,
    parameter int PROG_DQ6_NS   = 2000,
    parameter int ERASE_PROT_NS = 100000,
    parameter int DW            = 8,
    localparam int P7_CYC = flash_status_pkg::ns_to_cycles(PROG_DQ7_NS, CLK_PERIOD_NS),
    localparam int P6_CYC = flash_status_pkg::ns_to_cycles(PROG_DQ6_NS, CLK_PERIOD_NS),
    localparam int E_CYC  = flash_status_pkg::ns_to_cycles(ERASE_PROT_NS, CLK_PERIOD_NS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_start,
    input  logic [1:0]    op_kind,
    input  logic          busy,
    input  logic [DW-1:0] prog_data,
    input  logic          prog_prot,
    input  logic          erase_prot,
    input  logic          oe_n,
    input  logic          ce_n,
    input  logic [DW-1:0] array_data,
    output logic [DW-1:0] rd_data
);
    import flash_status_pkg::*;

    op_kind_e kind;
    logic     datum7_q;
    logic     rd_edge;
    logic     tog_q;
    logic     tog_en;
    logic     tog_clr;
    logic     ph7_win;
    logic     ph6_win;
    logic     ph_erase;
    logic     start_prot;
    logic     is_prog;
    logic     dq7_ovr;
    logic     dq7_val;
    logic     dq6_ovr;

    assign kind    = op_kind_e'(op_kind);
    assign is_prog = (kind == OPK_PROG) || (kind == OPK_SPROG);

    assign start_prot = op_start &&
                        ((is_prog && prog_prot) || (kind == OPK_ERASE && erase_prot));
    assign tog_clr    = op_start && (kind != OPK_SUSP);

    // Latch bit 7 of the datum when a program-type operation starts.
    always_ff @(posedge clk) begin
        if (!rst_n)                 datum7_q <= 1'b0;
        else if (op_start && is_prog) datum7_q <= prog_data[DW-1];
    end

    fsg_read_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .oe_n    (oe_n),
        .ce_n    (ce_n),
        .rd_edge (rd_edge)
    );

    fsg_phantom_timer #(
        .P7_CYC (P7_CYC),
        .P6_CYC (P6_CYC),
        .E_CYC  (E_CYC)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_prot (start_prot),
        .cancel     (op_start),
        .sel_erase  (kind == OPK_ERASE),
        .win7       (ph7_win),
        .win6       (ph6_win),
        .is_erase   (ph_erase)
    );

    assign tog_en = ph6_win || (!ph7_win && busy && kind != OPK_SUSP);

    fsg_toggle_bit u_tog (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tog_clr),
        .enable  (tog_en),
        .rd_edge (rd_edge),
        .tog_q   (tog_q)
    );

    // Pick which status bits replace array data, with windows taking priority.
    always_comb begin
        dq7_ovr = 1'b0;
        dq7_val = 1'b0;
        dq6_ovr = 1'b0;
        if (ph6_win) begin
            dq6_ovr = 1'b1;
            if (ph7_win) begin
                dq7_ovr = 1'b1;
                dq7_val = ph_erase ? 1'b0 : !datum7_q;
            end
        end else if (kind == OPK_SUSP) begin
            dq7_ovr = 1'b1;
            dq7_val = 1'b1;
            dq6_ovr = 1'b1;
        end else if (busy) begin
            dq7_ovr = 1'b1;
            dq7_val = (kind == OPK_ERASE) ? 1'b0 : !datum7_q;
            dq6_ovr = 1'b1;
        end
    end

    // Merge status bits into the array data.
    always_comb begin
        rd_data       = array_data;
        rd_data[DW-1] = dq7_ovr ? dq7_val : array_data[DW-1];
        rd_data[DW-2] = dq6_ovr ? tog_q   : array_data[DW-2];
    end
endmodule

// File: rtl/flash_status_gen_chk.sv
// Checker for flash_status_gen. It watches ports plus the window and toggle
// state that the submodules drive. Attached by bind below.
module flash_status_gen_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_start,
    input logic [1:0]    op_kind,
    input logic          busy,
    input logic [DW-1:0] array_data,
    input logic [DW-1:0] rd_data,
    input logic          ph7,
    input logic          ph6,
    input logic          datum7,
    input logic          rd_edge,
    input logic          tog_en,
    input logic          tog_q
);
    assert_low_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DW-3:0] == array_data[DW-3:0]);

    assert_prog_poll_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ph6 && (op_kind == 2'd0 || op_kind == 2'd3)) |-> rd_data[DW-1] == !datum7);

    assert_erase_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ph6 && op_kind == 2'd1) |-> rd_data[DW-1] == 1'b0);

    assert_toggle_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_edge && tog_en && !op_start) |=> tog_q != $past(tog_q));

    assert_susp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == 2'd2 && !ph6 && !op_start) |=>
            (op_kind != 2'd2 || ph6 || $stable(rd_data[DW-2])));

    assert_win_nest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ph7 |-> ph6);

    assert_idle_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op_kind != 2'd2 && !ph6) |-> rd_data == array_data);
endmodule

bind flash_status_gen flash_status_gen_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_start   (op_start),
    .op_kind    (op_kind),
    .busy       (busy),
    .array_data (array_data),
    .rd_data    (rd_data),
    .ph7        (ph7_win),
    .ph6        (ph6_win),
    .datum7     (datum7_q),
    .rd_edge    (rd_edge),
    .tog_en     (tog_en),
    .tog_q      (tog_q)
);

// File: tb/flash_status_gen_tb.sv
// Directed bench for flash_status_gen: one task per scenario.
module flash_status_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_start = 1'b0;
    logic [1:0] op_kind = 2'd0;
    logic       busy = 1'b0;
    logic [7:0] prog_data = 8'h00;
    logic       prog_prot = 1'b0;
    logic       erase_prot = 1'b0;
    logic       oe_n = 1'b1;
    logic       ce_n = 1'b1;
    logic [7:0] array_data = 8'h5A;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = !clk;

    flash_status_gen u_dut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
        .busy(busy), .prog_data(prog_data), .prog_prot(prog_prot),
        .erase_prot(erase_prot), .oe_n(oe_n), .ce_n(ce_n),
        .array_data(array_data), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One full read using both strobes; returns data seen mid-read.
    task automatic do_read(output logic [7:0] d);
        oe_n = 1'b0; ce_n = 1'b0;
        cycles(3);
        d = rd_data;
        oe_n = 1'b1; ce_n = 1'b1;
        cycles(2);
    endtask

    task automatic start_op(input logic [1:0] k, input logic [7:0] dat);
        op_kind = k; prog_data = dat; op_start = 1'b1;
        cycles(1);
        op_start = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        cycles(1);
        chk("R1 reset passthrough", rd_data, array_data);
        do_read(d);
        chk("R1 reset read", d, 8'h5A);
    endtask

    task automatic t_program();
        logic [7:0] d;
        array_data = 8'h3C;
        start_op(2'd0, 8'h80);
        busy = 1'b1;
        do_read(d);
        chk("R2 prog poll inverted, R4 first toggle 1", d, 8'h7C);
        do_read(d);
        chk("R4 second read toggle 0", d, 8'h3C);
        do_read(d);
        chk("R4 third read toggle 1", d, 8'h7C);
        busy = 1'b0; array_data = 8'hC5;
        cycles(1);
        do_read(d);
        chk("R2 prog done true data R10", d, 8'hC5);
    endtask

    task automatic t_erase_suspend();
        logic [7:0] d;
        array_data = 8'hFF;
        start_op(2'd1, 8'h00);
        busy = 1'b1;
        do_read(d);
        chk("R3 erase poll 0 toggle 1", d, 8'h7F);
        do_read(d);
        chk("R3 erase poll 0 toggle 0", d, 8'h3F);
        do_read(d);
        chk("R3 erase toggle 1", d, 8'h7F);
        op_kind = 2'd2;
        cycles(1);
        do_read(d);
        chk("R6 suspend poll 1 toggle held", d, 8'hFF);
        array_data = 8'h00;
        do_read(d);
        chk("R6 suspend second read held", d, 8'hC0);
        op_kind = 2'd1;
        cycles(1);
        do_read(d);
        chk("R6 resume toggles from held", d, 8'h00);
        busy = 1'b0; array_data = 8'hFF;
        cycles(1);
        do_read(d);
        chk("R3 erase done array", d, 8'hFF);
    endtask

    task automatic t_susp_prog();
        logic [7:0] d;
        array_data = 8'h12;
        start_op(2'd3, 8'h00);
        busy = 1'b1;
        do_read(d);
        chk("R5 suspend-program poll and toggle", d, 8'hD2);
        do_read(d);
        chk("R5 suspend-program second toggle", d, 8'h92);
        busy = 1'b0;
        op_kind = 2'd0;
        cycles(1);
        chk("R5 suspend-program done", rd_data, 8'h12);
    endtask

    task automatic t_strobes();
        logic [7:0] d;
        array_data = 8'h00;
        start_op(2'd0, 8'hFF);
        busy = 1'b1;
        cycles(1);
        chk("R7 no read yet toggle 0", rd_data, 8'h00);
        oe_n = 1'b0;
        cycles(4);
        chk("R7 oe only no read", rd_data, 8'h00);
        ce_n = 1'b0;
        cycles(6);
        chk("R7 held read counts once", rd_data, 8'h40);
        ce_n = 1'b1;
        cycles(2);
        ce_n = 1'b0;
        cycles(2);
        chk("R7 ce-driven second read", rd_data, 8'h00);
        oe_n = 1'b1; ce_n = 1'b1;
        cycles(2);
        busy = 1'b0;
        cycles(1);
        d = rd_data;
        chk("R10 idle after strobes", d, 8'h00);
    endtask

    task automatic t_prot_prog();
        logic [7:0] d;
        array_data = 8'h00;
        prog_prot = 1'b1;
        start_op(2'd0, 8'h00);
        prog_prot = 1'b0;
        cycles(95);
        do_read(d);
        chk("R8 protected prog both windows", d, 8'hC0);
        cycles(195);
        do_read(d);
        chk("R8 poll window over toggle continues", d, 8'h00);
        cycles(295);
        do_read(d);
        chk("R8 both windows over array data", d, 8'h00);
        array_data = 8'hA5;
        cycles(1);
        chk("R10 idle passthrough after window", rd_data, 8'hA5);
    endtask

    task automatic t_prot_erase();
        logic [7:0] d;
        array_data = 8'hFF;
        erase_prot = 1'b1;
        start_op(2'd1, 8'h00);
        erase_prot = 1'b0;
        cycles(100);
        do_read(d);
        chk("R9 protected erase poll 0 toggle 1", d, 8'h7F);
        cycles(24500);
        do_read(d);
        chk("R9 protected erase still busy toggle 0", d, 8'h3F);
        cycles(500);
        do_read(d);
        chk("R9 protected erase ended", d, 8'hFF);
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        t_reset();
        t_program();
        t_erase_suspend();
        t_susp_prog();
        t_strobes();
        t_prot_prog();
        t_prot_erase();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule